// File: doc/BRIEF.md
# Programmable Tick Timer with Match Modes

This block is a processor tick timer. It holds a 32-bit count register and a control word. The control word carries a compare period, an interrupt enable, an interrupt pending flag and a two-bit match mode. While counting is active, the count advances by one on every cycle in which the tick-enable input is high. The tick-enable input is a strobe derived from the system clock; the nominal timer rate is 20 MHz, which is one tick every 50 ns.

On each advance, only the low period field of the new count is compared with the programmed period. A match with the interrupt enable set raises the pending flag, and the level interrupt output follows pending AND enable. The match mode then chooses what the count does next:
- it clears to zero and keeps going;
- it stops until software writes a non-zero mode again;
- it runs on without interruption.

In the disabled mode the count is frozen. Software reaches both registers through a plain single-cycle write port and a combinational read mux.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset, the control word and the count both read 0x00000000, and `irq` is low.
- R2: While counting is active, the count increases by exactly one in each cycle with `tick_en` high and holds in cycles without it. Counting is active when the mode is non-zero and no one-shot stop is in force. The count wraps modulo 2^32.
- R3: A match is the cycle in which an advance makes bits [27:0] of the new count equal to the period field (control bits [27:0]). Count bits [31:28] take no part in the compare. When the period is at or below the current masked count, the next match comes only after the masked field wraps from all-ones through zero up to the period.
- R4: A match while the enable bit (control bit 29) is 1 sets the pending bit (control bit 28). `irq` is high exactly while pending and enable are both 1.
- R5: Pending is cleared only by a software control write with bit 28 at 0. A match never clears it, and it stays set across later ticks.
- R6: With mode 01 (restart, control bits [31:30]), the count is 0 after a matching tick instead of the incremented value.
- R7: With mode 10 (one-shot), the count takes the matching value and then stops advancing. Any control write with a non-zero mode resumes counting.
- R8: With mode 11 (continuous), the count runs through a match unchanged in its progression. With mode 00 (disabled), the count never advances and no match occurs.
- R9: A count write (`wr_en`=1, `wr_sel`=1) loads `wr_data` and takes priority over a tick increment or a restart clear in the same cycle.
- R10: `rd_data` shows the control word when `rd_sel`=0 and the count when `rd_sel`=1, combinationally from the current register values.
- R11: A control write (`wr_en`=1, `wr_sel`=0) in the same cycle as a match wins: the control word becomes exactly `wr_data`, so a written 0 in bit 28 leaves pending clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle timer tick strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 count |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 control word, 1 count |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Level timer interrupt (pending AND enable) |

## Verification
Two pairs of events can fall in the same cycle. The first is a count write together with a tick that would increment or restart the count. The second is a control write together with a tick that produces a match. The bench provokes each pair by placing the count one step below the period in restart or continuous mode, then issuing the write in the very cycle the tick arrives. The resulting count, control word and `irq` are judged against a behavioural reference model that applies write-over-tick priority, and they are compared after every clock.

// File: rtl/tick_tmr_pkg.sv
package tick_tmr_pkg;

    localparam int CNT_W = 32;
    localparam int PER_W = 28;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_RESTART = 2'b01,
        MODE_ONESHOT = 2'b10,
        MODE_FREE    = 2'b11
    } tmr_mode_e;

    // Control word, packed MSB first: mode | enable | pending | period
    typedef struct packed {
        tmr_mode_e          mode;
        logic               ie;
        logic               ip;
        logic [PER_W-1:0]   period;
    } ctrl_t;

    function automatic logic mode_counts(input tmr_mode_e m);
        return m != MODE_OFF;
    endfunction

endpackage

// File: rtl/tt_match.sv
module tt_match
    import tick_tmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PER_W
) (
    input  logic [CW-1:0] count_q,
    input  logic [PW-1:0] period,
    input  logic          advance,
    output logic [CW-1:0] count_inc,
    output logic          match
);
    always_comb begin
        count_inc = count_q + CW'(1);
        // only the period field of the advanced count takes part
        match     = advance && (count_inc[PW-1:0] == period);
    end
endmodule

// File: rtl/tt_count.sv
module tt_count
    import tick_tmr_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          advance,
    input  logic          clear,
    input  logic [CW-1:0] count_inc,
    output logic [CW-1:0] count_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (advance) begin
            count_q <= clear ? '0 : count_inc;
        end
    end
endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl
    import tick_tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  ctrl_t load_val,
    input  logic  match,
    output ctrl_t ctrl_q,
    output logic  running
);
    logic halted_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            halted_q <= 1'b0;
        end else if (load) begin
            ctrl_q   <= load_val;
            halted_q <= 1'b0;
        end else if (match) begin
            if (ctrl_q.ie) begin
                ctrl_q.ip <= 1'b1;
            end
            if (ctrl_q.mode == MODE_ONESHOT) begin
                halted_q <= 1'b1;
            end
        end
    end

    assign running = mode_counts(ctrl_q.mode) && !halted_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_tmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [CW-1:0] wr_data,
    input  logic          rd_sel,
    output logic [CW-1:0] rd_data,
    output logic          irq
);
    ctrl_t         ctrl_q;
    logic [CW-1:0] ctrl_word;
    logic [CW-1:0] count_q;
    logic [CW-1:0] count_inc;
    logic          running;
    logic          advance;
    logic          match;
    logic          ctrl_wr;
    logic          cnt_wr;

    assign ctrl_wr   = wr_en && !wr_sel;
    assign cnt_wr    = wr_en && wr_sel;
    assign advance   = tick_en && running;
    assign ctrl_word = ctrl_q;

    tt_match #(.CW(CW), .PW(PW)) u_match (
        .count_q   (count_q),
        .period    (ctrl_q.period),
        .advance   (advance),
        .count_inc (count_inc),
        .match     (match)
    );

    tt_count #(.CW(CW)) u_count (
        .clk       (clk),
        .rst       (rst),
        .load      (cnt_wr),
        .load_val  (wr_data),
        .advance   (advance),
        .clear     (match && (ctrl_q.mode == MODE_RESTART)),
        .count_inc (count_inc),
        .count_q   (count_q)
    );

    tt_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .load     (ctrl_wr),
        .load_val (ctrl_t'(wr_data)),
        .match    (match),
        .ctrl_q   (ctrl_q),
        .running  (running)
    );

    assign rd_data = rd_sel ? count_q : ctrl_word;
    assign irq     = ctrl_q.ip && ctrl_q.ie;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick_en,
    input logic        wr_en,
    input logic        wr_sel,
    input logic        irq,
    input logic [31:0] ctrl_q,
    input logic [31:0] count_q
);
    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q[28]) |-> $past(wr_en && !wr_sel));

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en && wr_sel) && (count_q != $past(count_q)))
            |-> ((count_q == 32'($past(count_q) + 32'd1)) || (count_q == 32'd0)));

    // R8
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en && wr_sel) && ($past(ctrl_q[31:30]) == 2'b00))
            |-> (count_q == $past(count_q)));

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en && wr_sel) && !$past(tick_en)) |-> (count_q == $past(count_q)));

    // R4
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(tick_en) || $past(wr_en && !wr_sel)));
endmodule

bind tick_timer tick_timer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .irq     (irq),
    .ctrl_q  (ctrl_word),
    .count_q (count_q)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference state
    bit [31:0] m_ctrl = 0;
    bit [31:0] m_cnt  = 0;
    bit        m_stop = 0;

    always #10 clk = ~clk;

    tick_timer dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string tag, input string what,
                         input bit [31:0] got, input bit [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic compare(input string tag);
        rd_sel = 1'b0;
        #1 check({tag, " R10"}, "control", rd_data, m_ctrl);
        rd_sel = 1'b1;
        #1 check({tag, " R10"}, "count", rd_data, m_cnt);
        check({tag, " R4"}, "irq", {31'd0, irq}, {31'd0, m_ctrl[28] & m_ctrl[29]});
    endtask

    // one clock: drive at negedge, update the model, compare at the next negedge
    task automatic step(input bit tk, input bit we, input bit sel,
                        input bit [31:0] d, input string tag);
        bit        run;
        bit        hit;
        bit [31:0] inc;
        bit [1:0]  md;
        tick_en = tk; wr_en = we; wr_sel = sel; wr_data = d;
        md  = m_ctrl[31:30];
        run = (md != 2'b00) && !m_stop;
        inc = m_cnt + 32'd1;
        hit = tk && run && ((inc & 32'h0FFF_FFFF) == (m_ctrl & 32'h0FFF_FFFF));
        @(posedge clk);
        if (we && sel)        m_cnt = d;
        else if (tk && run)   m_cnt = (hit && md == 2'b01) ? 32'd0 : inc;
        if (we && !sel) begin
            m_ctrl = d;
            m_stop = 1'b0;
        end else if (hit) begin
            if (m_ctrl[29]) m_ctrl[28] = 1'b1;
            if (md == 2'b10) m_stop = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        compare(tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 32'd0, tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R1");

        // disabled mode: nothing advances
        step(1'b0, 1'b1, 1'b0, 32'h2000_0002, "R8");
        ticks(5, "R8");

        // continuous with enable, period 3
        step(1'b0, 1'b1, 1'b0, 32'hE000_0003, "R8");
        ticks(8, "R4");
        // gapped ticks
        for (int i = 0; i < 6; i++) step(i[0], 1'b0, 1'b0, 32'd0, "R2");
        // software clears pending
        step(1'b0, 1'b1, 1'b0, 32'hE000_0003, "R5");
        ticks(3, "R5");

        // restart mode, period 4
        step(1'b0, 1'b1, 1'b1, 32'd0, "R9");
        step(1'b0, 1'b1, 1'b0, 32'h6000_0004, "R6");
        ticks(12, "R6");

        // one-shot, period 2
        step(1'b0, 1'b1, 1'b1, 32'd0, "R9");
        step(1'b0, 1'b1, 1'b0, 32'hA000_0002, "R7");
        ticks(6, "R7");
        step(1'b0, 1'b1, 1'b0, 32'hA000_0002, "R7");
        ticks(3, "R7");

        // upper count bits ignored, enable off
        step(1'b0, 1'b1, 1'b0, 32'hC000_0005, "R3");
        step(1'b0, 1'b1, 1'b1, 32'hF000_0002, "R3");
        ticks(5, "R3");
        // period below masked count: match only after field wrap
        step(1'b0, 1'b1, 1'b0, 32'hE000_0003, "R3");
        step(1'b0, 1'b1, 1'b1, 32'h0FFF_FFFC, "R3");
        ticks(8, "R3");

        // count write against a restart-clearing tick
        step(1'b0, 1'b1, 1'b0, 32'h6000_0002, "R9");
        step(1'b0, 1'b1, 1'b1, 32'd1, "R9");
        step(1'b1, 1'b1, 1'b1, 32'h0000_0055, "R9");
        ticks(2, "R9");

        // control write against a matching tick
        step(1'b0, 1'b1, 1'b0, 32'hE000_0006, "R11");
        step(1'b0, 1'b1, 1'b1, 32'd5, "R11");
        step(1'b1, 1'b1, 1'b0, 32'hE000_0006, "R11");
        ticks(2, "R11");

        // 32-bit wrap in continuous mode
        step(1'b0, 1'b1, 1'b1, 32'hFFFF_FFFE, "R2");
        ticks(3, "R2");

        // reset again
        rst = 1'b1;
        m_ctrl = 0; m_cnt = 0; m_stop = 0;
        @(negedge clk);
        rst = 1'b0;
        compare("R1");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule